// File: doc/BRIEF.md
# Pipelined Signed Booth Multiplier

This block multiplies two signed two's-complement operands and returns the full-width product three clock cycles later. It is meant to sit inside each tap of a filter datapath and accepts a fresh operand pair on every clock. The block has no stall input and no buffering at its edges. A valid flag travels beside the data so that gaps in the input stream appear as gaps at the output.

The work is split by function over three register stages. The first stage recodes the second operand into radix-4 signed digits and builds one shifted partial product per digit. It also builds a row of negation correction bits and a constant row that replaces explicit sign extension. The second stage reduces all of these rows with a tree of 3:2 carry-save compressors to a single sum vector and a single carry vector. The third stage adds those two vectors in a two-level carry-lookahead adder made of 4-bit groups.

Top module: `booth_mul3`

## Requirements
- R1: When `out_valid` is high, `product` equals the signed product of the `a` and `b` accepted three cycles earlier, as a 2N-bit two's-complement value with no truncation.
- R2: `out_valid` is high in a cycle exactly when `in_valid` was high three clock edges earlier and no reset edge came in between. The data keeps step with it.
- R3: A new operand pair is accepted on every clock with `in_valid` high, and back-to-back pairs each give a correct product on consecutive cycles.
- R4: The operand `b` is recoded into ceil(N/2) digits. Digit i is taken from bits 2i+1, 2i and 2i-1 of `b`, with an implicit 0 below bit 0 and `b` sign-extended above its top bit. Its value is -2*b[2i+1] + b[2i] + b[2i-1], so it lies in {-2,-1,0,+1,+2}.
- R5: A negative digit contributes the one's complement of the selected multiple of `a` plus a correction 1 at bit 2i. The rows of the first stage, with the correction row and the sign-extension constant row, sum modulo 2^(2N) to a*b.
- R6: After the second stage, the sum vector plus the carry vector equals a*b modulo 2^(2N).
- R7: The final adder output equals the sum of the two vectors held in the second stage on the previous cycle. Every carry is formed by lookahead from group generate and propagate terms.
- R8: A synchronous active-high `rst` clears all three stage valids, so `out_valid` is low on the cycle after a reset edge and stays low until new valid data has travelled the full pipeline.
- R9: Corner operands give exact results: the most negative value squared gives +2^(2N-2), zero times anything gives 0, and minus one times x gives -x.
- R10: A cycle with `in_valid` low produces a cycle with `out_valid` low three cycles later, even between valid cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on `a`/`b` is valid this cycle |
| a | input | N | Multiplicand, signed |
| b | input | N | Multiplier (recoded operand), signed |
| out_valid | output | 1 | `product` holds a valid result |
| product | output | 2N | Signed product |

## Verification
The stage checks compare each pipeline register with the product of the operands sampled one, two or three cycles before. They therefore assume that the operand ports are stable and free of unknown bits whenever `in_valid` is high, and that reset has been held for longer than the pipeline depth before the first valid pair. The stimulus drives fully defined operands on every cycle, including idle ones, and holds reset for five cycles at the start. A later reset pulse is applied only after at least three cycles of ordinary traffic.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Control lines for one radix-4 digit
    typedef struct packed {
        logic neg;   // digit is negative
        logic one;   // magnitude 1
        logic two;   // magnitude 2
    } booth_dig_t;

    // Decode a 3-bit window {b[2i+1], b[2i], b[2i-1]} into a digit
    function automatic booth_dig_t booth_digit(input logic [2:0] win);
        booth_dig_t d;
        d.one = win[1] ^ win[0];
        d.two = (win == 3'b011) || (win == 3'b100);
        d.neg = win[2] & ~(win[1] & win[0]);
        return d;
    endfunction

    function automatic int pp_count(input int n);
        return (n + 1) / 2;
    endfunction

    // Rows left after one layer of 3:2 compression
    function automatic int csa_next(input int c);
        return 2 * (c / 3) + (c % 3);
    endfunction

    function automatic int csa_levels(input int c);
        int cur = c;
        int lv = 0;
        while (cur > 2) begin
            cur = csa_next(cur);
            lv++;
        end
        return lv;
    endfunction

    function automatic int rows_at(input int c, input int lvl);
        int cur = c;
        for (int i = 0; i < lvl; i++) cur = csa_next(cur);
        return cur;
    endfunction

    // Constant replacing sign extension: -sum 2^(n+2i), modulo 2^64
    function automatic logic [63:0] sx_const(input int n, input int npp);
        logic [63:0] acc = '0;
        for (int i = 0; i < npp; i++) acc = acc - (64'd1 << (n + 2 * i));
        return acc;
    endfunction

endpackage

// File: rtl/booth_pp_stage.sv
module booth_pp_stage #(
    parameter int N    = 16,
    parameter int W    = 2 * N,
    parameter int NPP  = (N + 1) / 2,
    parameter int ROWS = NPP + 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic         out_v,
    output logic [W-1:0] rows_q [ROWS]
);
    import booth_pkg::*;

    localparam int BX = 2 * NPP;
    localparam logic [63:0] SX_ALL = sx_const(N, NPP);
    localparam logic [W-1:0] SX_ROW = SX_ALL[W-1:0];

    logic signed [BX-1:0] b_se;
    logic [BX:0]          b_win;
    logic [N:0]           a_one;
    logic [N:0]           a_two;
    logic [W-1:0]         rows_d [ROWS];
    logic [W-1:0]         corr;

    assign b_se  = BX'($signed(b));
    assign b_win = {b_se, 1'b0};
    assign a_one = {a[N-1], a};
    assign a_two = {a, 1'b0};

    generate
        for (genvar i = 0; i < NPP; i++) begin : g_pp
            booth_dig_t dg;
            logic [N:0] mag;
            logic [N:0] pp;
            assign dg  = booth_digit(b_win[2*i+2 : 2*i]);
            assign mag = dg.one ? a_one : (dg.two ? a_two : '0);
            assign pp  = dg.neg ? ~mag : mag;
            assign rows_d[i] = W'({~pp[N], pp[N-1:0]}) << (2 * i);
            assign corr[2*i] = dg.neg;
            assign corr[2*i+1] = 1'b0;
        end
        if (W > 2 * NPP) begin : g_corr_hi
            assign corr[W-1:2*NPP] = '0;
        end
    endgenerate

    assign rows_d[NPP]     = corr;
    assign rows_d[NPP + 1] = SX_ROW;

    always_ff @(posedge clk) begin
        if (rst) out_v <= 1'b0;
        else     out_v <= in_v;
        for (int r = 0; r < ROWS; r++) rows_q[r] <= rows_d[r];
    end

endmodule

// File: rtl/booth_csa_tree.sv
module booth_csa_tree #(
    parameter int W    = 32,
    parameter int ROWS = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [W-1:0] rows [ROWS],
    output logic         out_v,
    output logic [W-1:0] sum_q,
    output logic [W-1:0] carry_q
);
    import booth_pkg::*;

    localparam int LEVELS = csa_levels(ROWS);

    logic [W-1:0] lv [LEVELS+1][ROWS];

    generate
        for (genvar k = 0; k < ROWS; k++) begin : g_l0
            assign lv[0][k] = rows[k];
        end
        for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            localparam int C = rows_at(ROWS, l);
            localparam int T = C / 3;
            localparam int R = C % 3;
            for (genvar k = 0; k < ROWS; k++) begin : g_row
                if (k < 2 * T) begin : g_csa
                    localparam int B = 3 * (k / 2);
                    if (k % 2 == 0) begin : g_s
                        assign lv[l+1][k] = lv[l][B] ^ lv[l][B+1] ^ lv[l][B+2];
                    end else begin : g_c
                        assign lv[l+1][k] = ((lv[l][B] & lv[l][B+1]) |
                                             (lv[l][B] & lv[l][B+2]) |
                                             (lv[l][B+1] & lv[l][B+2])) << 1;
                    end
                end else if (k < 2 * T + R) begin : g_pass
                    assign lv[l+1][k] = lv[l][3 * T + (k - 2 * T)];
                end else begin : g_zero
                    assign lv[l+1][k] = '0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) out_v <= 1'b0;
        else     out_v <= in_v;
        sum_q   <= lv[LEVELS][0];
        carry_q <= lv[LEVELS][1];
    end

endmodule

// File: rtl/booth_cla_stage.sv
module booth_cla_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic         out_v,
    output logic [W-1:0] sum_q
);
    localparam int G  = (W + 3) / 4;
    localparam int PW = 4 * G;

    logic [PW-1:0] xp, yp, p, g, c, s;
    logic [G-1:0]  gg, gp, gc;

    assign xp = PW'(x);
    assign yp = PW'(y);
    assign p  = xp ^ yp;
    assign g  = xp & yp;

    always_comb begin
        // Group generate / propagate
        for (int k = 0; k < G; k++) begin
            gp[k] = &p[4*k +: 4];
            gg[k] = g[4*k+3]
                  | (p[4*k+3] & g[4*k+2])
                  | (p[4*k+3] & p[4*k+2] & g[4*k+1])
                  | (p[4*k+3] & p[4*k+2] & p[4*k+1] & g[4*k]);
        end
        // Second level: every group carry expanded, no ripple
        for (int k = 0; k < G; k++) begin
            gc[k] = 1'b0;
            for (int j = 0; j < k; j++) begin
                logic term;
                term = gg[j];
                for (int m = j + 1; m < k; m++) term = term & gp[m];
                gc[k] = gc[k] | term;
            end
        end
        // Bit carries inside each group from its group carry
        for (int k = 0; k < G; k++) begin
            for (int t = 0; t < 4; t++) begin
                logic acc;
                logic chain;
                acc = 1'b0;
                for (int j = 0; j < t; j++) begin
                    chain = g[4*k+j];
                    for (int m = j + 1; m < t; m++) chain = chain & p[4*k+m];
                    acc = acc | chain;
                end
                chain = gc[k];
                for (int m = 0; m < t; m++) chain = chain & p[4*k+m];
                c[4*k+t] = acc | chain;
            end
        end
        s = p ^ c;
    end

    always_ff @(posedge clk) begin
        if (rst) out_v <= 1'b0;
        else     out_v <= in_v;
        sum_q <= s[W-1:0];
    end

endmodule

// File: rtl/booth_mul3.sv
module booth_mul3 #(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic           out_valid,
    output logic [2*N-1:0] product
);
    localparam int W    = 2 * N;
    localparam int NPP  = booth_pkg::pp_count(N);
    localparam int ROWS = NPP + 2;

    logic         s1_v;
    logic [W-1:0] s1_rows [ROWS];
    logic         s2_v;
    logic [W-1:0] s2_sum;
    logic [W-1:0] s2_carry;

    booth_pp_stage #(.N(N), .W(W), .NPP(NPP), .ROWS(ROWS)) u_pp (
        .clk    (clk),
        .rst    (rst),
        .in_v   (in_valid),
        .a      (a),
        .b      (b),
        .out_v  (s1_v),
        .rows_q (s1_rows)
    );

    booth_csa_tree #(.W(W), .ROWS(ROWS)) u_csa (
        .clk     (clk),
        .rst     (rst),
        .in_v    (s1_v),
        .rows    (s1_rows),
        .out_v   (s2_v),
        .sum_q   (s2_sum),
        .carry_q (s2_carry)
    );

    booth_cla_stage #(.W(W)) u_cla (
        .clk   (clk),
        .rst   (rst),
        .in_v  (s2_v),
        .x     (s2_sum),
        .y     (s2_carry),
        .out_v (out_valid),
        .sum_q (product)
    );

endmodule

// File: rtl/booth_mul3_chk.sv
module booth_mul3_chk #(
    parameter int N    = 16,
    parameter int W    = 2 * N,
    parameter int ROWS = (N + 1) / 2 + 2
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         out_valid,
    input logic [W-1:0] product,
    input logic         s1_v,
    input logic [W-1:0] s1_rows [ROWS],
    input logic         s2_v,
    input logic [W-1:0] s2_sum,
    input logic [W-1:0] s2_carry
);
    logic signed [W-1:0] ax, bx, mul_now;
    logic [W-1:0]        row_total;
    logic [W-1:0]        vec_total;

    assign ax        = $signed(a);
    assign bx        = $signed(b);
    assign mul_now   = ax * bx;
    assign vec_total = s2_sum + s2_carry;

    always_comb begin
        row_total = '0;
        for (int r = 0; r < ROWS; r++) row_total = row_total + s1_rows[r];
    end

    // R4 R5
    stage1_rows_chk: assert property (@(posedge clk) disable iff (rst)
        s1_v |-> row_total == $past(mul_now));

    // R6
    csa_pair_chk: assert property (@(posedge clk) disable iff (rst)
        s2_v |-> vec_total == $past(mul_now, 2));

    // R7
    cla_sum_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> product == $past(vec_total));

    // R1
    product_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> product == $past(mul_now, 3));

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    // R10
    bubble_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid, 3) |-> !out_valid);

endmodule

bind booth_mul3 booth_mul3_chk #(.N(N), .W(W), .ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .product   (product),
    .s1_v      (s1_v),
    .s1_rows   (s1_rows),
    .s2_v      (s2_v),
    .s2_sum    (s2_sum),
    .s2_carry  (s2_carry)
);

// File: tb/booth_mul3_tb.sv
module booth_mul3_tb;
    localparam int N = 16;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic         out_valid;
    logic [W-1:0] product;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        bit           v;
        logic [W-1:0] p;
        string        tag;
    } exp_t;

    exp_t pipe[$];

    always #10 clk = ~clk;

    booth_mul3 #(.N(N)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .product   (product)
    );

    function automatic logic [W-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        longint sx, sy;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        return W'(sx * sy);
    endfunction

    // Called just after a falling edge: compare the oldest entry, then drive
    task automatic step(input bit v, input logic [N-1:0] x, input logic [N-1:0] y,
                        input string tag, input bit r = 0);
        exp_t e;
        @(negedge clk);
        if (pipe.size() == 3) begin
            e = pipe.pop_front();
            checks++;
            if (out_valid !== e.v) begin
                failures++;
                $display("FAIL %s out_valid actual=%b expected=%b", e.tag, out_valid, e.v);
            end
            if (e.v) begin
                checks++;
                if (product !== e.p) begin
                    failures++;
                    $display("FAIL %s product actual=%h expected=%h", e.tag, product, e.p);
                end
            end
        end
        if (r) foreach (pipe[k]) begin
            pipe[k].v = 0;
            pipe[k].tag = "R8";
        end
        rst      = r;
        in_valid = v;
        a        = x;
        b        = y;
        e.v   = v && !r;
        e.p   = ref_mul(x, y);
        e.tag = r ? "R8" : tag;
        pipe.push_back(e);
    endtask

    initial begin
        // reset held five cycles (R8)
        for (int i = 0; i < 5; i++) step(1, 16'h1234, 16'h0042, "R8", 1);
        for (int i = 0; i < 3; i++) step(0, 16'h0, 16'h0, "R8");
        // R9 corners
        step(1, 16'h8000, 16'h8000, "R9");
        step(1, 16'h0000, 16'h7abc, "R9");
        step(1, 16'h5a5a, 16'h0000, "R9");
        step(1, 16'hffff, 16'h1357, "R9");
        step(1, 16'h2468, 16'hffff, "R9");
        step(1, 16'hffff, 16'hffff, "R9");
        step(1, 16'h7fff, 16'h8000, "R9");
        step(1, 16'h7fff, 16'h7fff, "R9");
        // R4 R5: digit patterns with runs of every digit value
        step(1, 16'h7fff, 16'haaaa, "R4");
        step(1, 16'h8001, 16'h5555, "R4");
        step(1, 16'h1234, 16'h3333, "R4");
        step(1, 16'hcdef, 16'hcccc, "R5");
        step(1, 16'h8000, 16'h6666, "R5");
        step(1, 16'h0001, 16'h9999, "R5");
        // R3 R6 R7: back-to-back random stream
        for (int i = 0; i < 300; i++)
            step(1, N'($urandom), N'($urandom), "R3");
        // R10: random bubbles between valid pairs
        for (int i = 0; i < 300; i++)
            step(($urandom % 3) != 0, N'($urandom), N'($urandom), "R10");
        // R8: reset during traffic, then resume
        for (int i = 0; i < 4; i++) step(1, N'($urandom), N'($urandom), "R6");
        step(1, 16'h4444, 16'h3333, "R8", 1);
        for (int i = 0; i < 6; i++) step(1, N'($urandom), N'($urandom), "R7");
        for (int i = 0; i < 4; i++) step(0, 16'h0, 16'h0, "R2");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired before stimulus finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule